// File: doc/BRIEF.md
# Kernel Segment Address Mapper

This block sits in front of a paged translation buffer and decides, for every 32-bit virtual address, how it is translated. With translation switched off, the address passes straight through with every permission granted. With translation on, a kernel-mode access can fall into one of sixteen 256 MiB segments that are set to direct mapping. The top four address bits are then replaced by a 4-bit base taken from one of two packed base registers, and the access is again granted every permission.

Every other access is sent to the paged buffer. The block raises a flag that tells the caller to use the paged result, and a second flag that picks the instruction-side buffer for fetches or the data-side buffer for loads and stores. The block is purely combinational and holds no state.

Top module: `seg_addr_mapper`

## Requirements
- R1: Translation is on exactly when at least one of cfg_global[3:2] is 1. Every other bit of cfg_global has no effect.
- R2: With translation off, phys_addr equals vaddr, full_perm is 1, and use_tlb and tlb_insn are 0, whatever the other inputs are.
- R3: The segment number is vaddr[31:28]. With translation on and user_mode 0, the segment is direct-mapped exactly when cfg_seg_en bit [segment] is 1. Bits [31:16] of cfg_seg_en have no effect.
- R4: The base of segment s is the 4-bit field seg_base_lo[4k+3:4k] for s < 8, and seg_base_hi[4k+3:4k] for s >= 8, where k = s mod 8.
- R5: For a direct-mapped access, phys_addr is {base, vaddr[27:0]}, full_perm is 1 and use_tlb is 0.
- R6: An access with user_mode 1 and translation on is never direct-mapped, even when its segment enable bit is set.
- R7: With translation on and no direct mapping, use_tlb is 1, full_perm is 0 and phys_addr is 0. Exactly one of use_tlb and full_perm is 1 at all times.
- R8: acc_type is encoded as 00 read, 01 write, 10 execute and 11 (treated as read). tlb_insn is 1 only when use_tlb is 1 and acc_type is 10. Otherwise it is 0, which selects the data side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vaddr | input | 32 | Virtual address |
| acc_type | input | 2 | Access kind: 00 read, 01 write, 10 execute, 11 read |
| user_mode | input | 1 | 1 for a user-mode access |
| cfg_global | input | 32 | Global configuration; bits [3:2] turn translation on |
| cfg_seg_en | input | 32 | Per-segment direct-map enables in bits [15:0] |
| seg_base_lo | input | 32 | Packed 4-bit bases for segments 0..7 |
| seg_base_hi | input | 32 | Packed 4-bit bases for segments 8..15 |
| phys_addr | output | 32 | Translated address (0 when the paged buffer is needed) |
| full_perm | output | 1 | Access granted with every permission, no fault |
| use_tlb | output | 1 | Caller must take the paged buffer result |
| tlb_insn | output | 1 | Paged lookup goes to the instruction side |

## Verification
Directed patterns come first. Translation is turned on through bit 2 alone and through bit 3 alone, which separates the enable decode from a single-bit test, while stray bits elsewhere in cfg_global show they are ignored. A sweep over all sixteen segments, with a distinct base in every field, tells the low register from the high one and shows that each segment reads its own field. The same sweep in user mode, and with enable bits cleared or only set in [31:16], shows when mapping is refused. All four access codes are then sent to the paged path to separate the instruction side from the data side. A long run of mixed random values finishes the test.

// File: rtl/seg_map_pkg.sv
package seg_map_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_EXEC  = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_e;
endpackage

// File: rtl/seg_enable_dec.sv
module seg_enable_dec #(
  parameter int CFG_W  = 32,
  parameter int EN_LSB = 2,
  parameter int EN_MSB = 3
) (
  input  logic [CFG_W-1:0] cfg_global,
  output logic             xlat_on
);
  logic unused_cfg_bits;

  assign xlat_on = |cfg_global[EN_MSB:EN_LSB];

  generate
    if (EN_LSB > 0 && EN_MSB < CFG_W-1) begin : g_both
      assign unused_cfg_bits = ^{cfg_global[CFG_W-1:EN_MSB+1], cfg_global[EN_LSB-1:0]};
    end else if (EN_LSB > 0) begin : g_low
      assign unused_cfg_bits = ^cfg_global[EN_LSB-1:0];
    end else if (EN_MSB < CFG_W-1) begin : g_high
      assign unused_cfg_bits = ^cfg_global[CFG_W-1:EN_MSB+1];
    end else begin : g_none
      assign unused_cfg_bits = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/seg_base_sel.sv
module seg_base_sel #(
  parameter int SEG_W = 4,
  parameter int NIB_W = 4,
  parameter int REG_W = 32
) (
  input  logic [SEG_W-1:0] seg_idx,
  input  logic [REG_W-1:0] base_lo,
  input  logic [REG_W-1:0] base_hi,
  output logic [NIB_W-1:0] base_nib
);
  localparam int HALF = (2**SEG_W) / 2;
  localparam int SUB_W = SEG_W - 1;

  logic [NIB_W-1:0] nib_lo [HALF];
  logic [NIB_W-1:0] nib_hi [HALF];
  logic [SUB_W-1:0] sub_idx;
  logic             upper_half;

  generate
    for (genvar i = 0; i < HALF; i++) begin : g_unpack
      assign nib_lo[i] = base_lo[i*NIB_W +: NIB_W];
      assign nib_hi[i] = base_hi[i*NIB_W +: NIB_W];
    end
  endgenerate

  assign upper_half = seg_idx[SEG_W-1];
  assign sub_idx    = seg_idx[SUB_W-1:0];

  always_comb begin
    if (upper_half) base_nib = nib_hi[sub_idx];
    else            base_nib = nib_lo[sub_idx];
  end
endmodule

// File: rtl/seg_route.sv
module seg_route
  import seg_map_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SEG_W  = 4
) (
  input  logic [ADDR_W-1:0]     vaddr,
  input  acc_e                  acc,
  input  logic                  user_mode,
  input  logic                  xlat_on,
  input  logic [2**SEG_W-1:0]   seg_en,
  input  logic [SEG_W-1:0]      base_nib,
  output logic [ADDR_W-1:0]     phys_addr,
  output logic                  full_perm,
  output logic                  use_tlb,
  output logic                  tlb_insn
);
  localparam int OFF_W = ADDR_W - SEG_W;

  logic [SEG_W-1:0] seg_idx;
  logic             seg_mapped;

  assign seg_idx    = vaddr[ADDR_W-1:OFF_W];
  assign seg_mapped = xlat_on && !user_mode && seg_en[seg_idx];

  always_comb begin
    phys_addr = '0;
    full_perm = 1'b0;
    use_tlb   = 1'b0;
    tlb_insn  = 1'b0;
    if (!xlat_on) begin
      phys_addr = vaddr;
      full_perm = 1'b1;
    end else if (seg_mapped) begin
      phys_addr = {base_nib, vaddr[OFF_W-1:0]};
      full_perm = 1'b1;
    end else begin
      use_tlb  = 1'b1;
      tlb_insn = (acc == ACC_EXEC);
    end
  end

  always_comb begin
    if (xlat_on && user_mode)
      AST_USER_NEVER_SEG: assert (use_tlb); // R6
    if (use_tlb)
      AST_TLB_ZERO_ADDR: assert (phys_addr == '0); // R7
  end
endmodule

// File: rtl/seg_addr_mapper.sv
module seg_addr_mapper
  import seg_map_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CFG_W  = 32,
  parameter int SEG_W  = 4
) (
  input  logic [ADDR_W-1:0] vaddr,
  input  logic [1:0]        acc_type,
  input  logic              user_mode,
  input  logic [CFG_W-1:0]  cfg_global,
  input  logic [CFG_W-1:0]  cfg_seg_en,
  input  logic [CFG_W-1:0]  seg_base_lo,
  input  logic [CFG_W-1:0]  seg_base_hi,
  output logic [ADDR_W-1:0] phys_addr,
  output logic              full_perm,
  output logic              use_tlb,
  output logic              tlb_insn
);
  localparam int NUM_SEG = 2**SEG_W;
  localparam int OFF_W   = ADDR_W - SEG_W;

  logic             xlat_on;
  logic [SEG_W-1:0] base_nib;
  logic             unused_seg_en_hi;
  acc_e             acc;

  assign acc              = acc_e'(acc_type);
  assign unused_seg_en_hi = ^cfg_seg_en[CFG_W-1:NUM_SEG];

  seg_enable_dec #(.CFG_W(CFG_W), .EN_LSB(2), .EN_MSB(3)) u_en (
    .cfg_global (cfg_global),
    .xlat_on    (xlat_on)
  );

  seg_base_sel #(.SEG_W(SEG_W), .NIB_W(SEG_W), .REG_W(CFG_W)) u_base (
    .seg_idx  (vaddr[ADDR_W-1:OFF_W]),
    .base_lo  (seg_base_lo),
    .base_hi  (seg_base_hi),
    .base_nib (base_nib)
  );

  seg_route #(.ADDR_W(ADDR_W), .SEG_W(SEG_W)) u_route (
    .vaddr     (vaddr),
    .acc       (acc),
    .user_mode (user_mode),
    .xlat_on   (xlat_on),
    .seg_en    (cfg_seg_en[NUM_SEG-1:0]),
    .base_nib  (base_nib),
    .phys_addr (phys_addr),
    .full_perm (full_perm),
    .use_tlb   (use_tlb),
    .tlb_insn  (tlb_insn)
  );

  always_comb begin
    if (cfg_global[3:2] == 2'b00)
      AST_PASS_THROUGH: assert (phys_addr == vaddr && full_perm && !use_tlb); // R2
    AST_ONE_OUTCOME: assert (full_perm != use_tlb); // R7
    if (tlb_insn)
      AST_INSN_SIDE: assert (use_tlb && acc_type == 2'b10); // R8
    if (full_perm)
      AST_LOW_BITS_KEPT: assert (phys_addr[OFF_W-1:0] == vaddr[OFF_W-1:0]); // R5
  end
endmodule

// File: tb/sim_seg_addr_mapper.sv
module sim_seg_addr_mapper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] vaddr = '0;
  logic [1:0]  acc_type = '0;
  logic        user_mode = 1'b0;
  logic [31:0] cfg_global = '0;
  logic [31:0] cfg_seg_en = '0;
  logic [31:0] seg_base_lo = '0;
  logic [31:0] seg_base_hi = '0;
  logic [31:0] phys_addr;
  logic        full_perm, use_tlb, tlb_insn;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  seg_addr_mapper u0 (
    .vaddr(vaddr), .acc_type(acc_type), .user_mode(user_mode),
    .cfg_global(cfg_global), .cfg_seg_en(cfg_seg_en),
    .seg_base_lo(seg_base_lo), .seg_base_hi(seg_base_hi),
    .phys_addr(phys_addr), .full_perm(full_perm),
    .use_tlb(use_tlb), .tlb_insn(tlb_insn)
  );

  always #2 clk = ~clk;

  task automatic check(input string tag);
    longint unsigned va, gc, me, lo, hi, seg, reg_v, nib, e_phys;
    int e_perm, e_tlb, e_ins;
    string why;
    va = vaddr; gc = cfg_global; me = cfg_seg_en; lo = seg_base_lo; hi = seg_base_hi;
    seg = va / 64'h1000_0000;
    if (((gc / 4) % 4) == 0) begin
      e_phys = va; e_perm = 1; e_tlb = 0; e_ins = 0; why = "R2";
    end else if (!user_mode && ((me >> seg) % 2) == 1) begin
      reg_v = (seg < 8) ? lo : hi;
      nib = (reg_v >> (4 * (seg % 8))) % 16;
      e_phys = nib * 64'h1000_0000 + (va % 64'h1000_0000);
      e_perm = 1; e_tlb = 0; e_ins = 0; why = "R5";
    end else begin
      e_phys = 0; e_perm = 0; e_tlb = 1; e_ins = (acc_type == 2) ? 1 : 0;
      why = user_mode ? "R6" : "R7";
    end
    n_cmp++;
    if (phys_addr !== e_phys[31:0] || full_perm !== e_perm[0] ||
        use_tlb !== e_tlb[0] || tlb_insn !== e_ins[0]) begin
      n_bad++;
      $display("FAIL %s/%s: got phys=%h perm=%0b tlb=%0b ins=%0b exp phys=%h perm=%0d tlb=%0d ins=%0d",
               tag, why, phys_addr, full_perm, use_tlb, tlb_insn,
               e_phys[31:0], e_perm, e_tlb, e_ins);
    end
  endtask

  task automatic drive(input logic [31:0] va, input logic [1:0] acc, input logic usr,
                       input logic [31:0] gc, input logic [31:0] me,
                       input logic [31:0] lo, input logic [31:0] hi, input string tag);
    @(negedge clk);
    vaddr = va; acc_type = acc; user_mode = usr;
    cfg_global = gc; cfg_seg_en = me; seg_base_lo = lo; seg_base_hi = hi;
    #1;
    check(tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2_reset");
    // R1 / R2: off with stray bits elsewhere, full pass-through
    drive(32'hDEAD_BEEF, 2'b10, 1'b1, 32'hFFFF_FFF3, 32'hFFFF, 32'h1234_5678, 32'h9ABC_DEF0, "R1_off_stray");
    drive(32'h8000_0004, 2'b01, 1'b0, 32'h0000_0000, 32'hFFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2_off");
    // R1: bit 2 alone, bit 3 alone
    drive(32'h3000_1234, 2'b00, 1'b0, 32'h0000_0004, 32'h0008, 32'h7654_3210, 32'hFEDC_BA98, "R1_bit2");
    drive(32'h3000_1234, 2'b00, 1'b0, 32'h0000_0008, 32'h0008, 32'h7654_3210, 32'hFEDC_BA98, "R1_bit3");
    // R3 / R4 / R5: sweep all segments kernel mode, distinct bases
    for (int s = 0; s < 16; s++)
      drive({s[3:0], 28'hABC_DEF1}, 2'b00, 1'b0, 32'h0000_000C, 32'h0000_FFFF,
            32'h5A3C_E197, 32'h2B4D_6F80, "R4_sweep");
    // R6: same sweep in user mode
    for (int s = 0; s < 16; s++)
      drive({s[3:0], 28'h000_0FF0}, 2'b00, 1'b1, 32'h0000_0004, 32'h0000_FFFF,
            32'h5A3C_E197, 32'h2B4D_6F80, "R6_user");
    // R3: enables only in upper half of cfg_seg_en are ignored
    for (int s = 0; s < 16; s++)
      drive({s[3:0], 28'h123_4567}, 2'b01, 1'b0, 32'h0000_0004, 32'hFFFF_0000,
            32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3_upper_ignored");
    // R3: single enable picks only its own segment
    drive(32'h9000_0010, 2'b00, 1'b0, 32'h4, 32'h0000_0200, 32'h0, 32'h0000_0050, "R3_single_hit");
    drive(32'hA000_0010, 2'b00, 1'b0, 32'h4, 32'h0000_0200, 32'h0, 32'h0000_0050, "R3_single_miss");
    // R8: access codes on the paged path
    for (int a = 0; a < 4; a++)
      drive(32'h4000_2000, a[1:0], 1'b0, 32'h8, 32'h0, 32'h0, 32'h0, "R8_acc");
    for (int a = 0; a < 4; a++)
      drive(32'h4000_2000, a[1:0], 1'b1, 32'h8, 32'hFFFF, 32'h0, 32'h0, "R8_user_acc");
    // R7 + mixed random patterns
    for (int i = 0; i < 600; i++)
      drive($urandom, 2'($urandom), 1'($urandom), $urandom, $urandom,
            $urandom, $urandom, "R7_random");
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (50000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: got timeout exp completion");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule